// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a watchdog timer that software must service on a regular basis. If software stops servicing it, the block escalates through up to three consecutive expiries. The first expiry raises an interrupt to the application core. The second expiry can raise a pulse to a management controller. The third expiry raises a reset request. A 2-bit mode value sets how far the escalation may go. A service write, called a poke, reloads the timer and returns the escalation to its first stage.

The timer has a 16-bit length field. On every reload, the length becomes the upper bits of a down-counter, and the lowest `LOW_BITS` bits of the counter start at zero. A prescaler divides the clock, so the counter moves once every `PRESCALE` clock cycles. The core interrupt sits behind a write-1-to-clear pending bit and an enable bit. The enable bit has a separate set address and a separate clear address. Pending, enable and poke all use the same bit position, `IDX`, within their 64-bit registers.

Software reaches the block through a simple word port. It has a write strobe, a read strobe and a 3-bit word address. Read data is registered and stays valid until the next read.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, the mode is 0 and all three outputs are low. Reads of the control word, the pending register and the enable register all return 0.
- R2: Address 0 is the control word. Its bits [1:0] hold the mode. While the mode is 0, the counter holds its value, the prescaler stays clear and no expiry occurs.
- R3: The control word places the mode at [1:0], the management-interrupt enable at bit 2, the length at [19:4] and the current count at bit 20 and up. The count field is read-only. Read data appears on the cycle after the read strobe and reflects the state from before that cycle's write.
- R4: When software writes a non-zero mode while the mode is 0, the counter loads the written length followed by `LOW_BITS` zero bits.
- R5: On every `PRESCALE`-th cycle of running, the counter decrements. If the counter is already zero on that cycle, an expiry happens instead.
- R6: In mode 1, every expiry sets the core pending bit and reloads the counter from the length field.
- R7: In mode 2, the first expiry sets core pending and reloads the counter. The second expiry gives a one-cycle management pulse if that interrupt is enabled, and the timer then holds.
- R8: In mode 3, the first two expiries act as in mode 2, except that the timer reloads after the second expiry. The third expiry gives a one-cycle reset request. The timer then holds and ignores pokes until software writes mode 0.
- R9: When the management enable bit (bit 2) is 0, the second expiry advances the stage and produces no output.
- R10: A write to address 4 with bit `IDX` set reloads the counter from the length field. It also clears the prescaler and restarts the escalation at stage 1. A write to address 4 with bit `IDX` clear has no effect.
- R11: Writing 1 to bit `IDX` at address 1 clears the core pending bit. Writing 0 to that bit leaves it unchanged.
- R12: Writing 1 to bit `IDX` at address 2 sets the enable bit. Writing 1 to bit `IDX` at address 3 clears it. The core interrupt output equals pending AND enable.
- R13: Writing mode 0 resets the stage and the prescaler immediately. A later non-zero mode write starts again from a full reload at stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address: 0 control, 1 pending, 2 enable set, 3 enable clear, 4 poke |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq_core | output | 1 | Core interrupt level (pending AND enable) |
| irq_mgmt | output | 1 | One-cycle pulse to the management controller |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench runs the timer through several sequences:

- **Mode sequences.** The timer expires freely in mode 1, mode 2 and mode 3. A cycle-exact reference model shows the difference between "repeat the first action" and "advance a stage", and it catches an off-by-one in either the prescaler or the zero-count test.
- **Poke sequences.** Pokes arrive mid-count, with the bit clear, and during the held state. These cases separate a real restart from a write that must be ignored.
- **Management enable.** Mode 3 runs with the management enable off. This shows that the second stage still advances without a pulse.
- **Interrupt control.** The pending and enable registers are written with and without bit `IDX` set. These writes check the masking of the core interrupt.
- **Control readback.** The control word is read throughout the run, which exposes the count value and the zero low bits after each reload.

// File: rtl/esc_wdg_pkg.sv
package esc_wdg_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CORE = 2'd1,
    MODE_MGMT = 2'd2,
    MODE_FULL = 2'd3
  } wdg_mode_e;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_PEND  = 3'd1;
  localparam logic [2:0] ADR_ENSET = 3'd2;
  localparam logic [2:0] ADR_ENCLR = 3'd3;
  localparam logic [2:0] ADR_POKE  = 3'd4;

  localparam int MGMT_EN_BIT = 2;
  localparam int LEN_LSB     = 4;

endpackage

// File: rtl/esc_wdg_prescaler.sv
module esc_wdg_prescaler #(
  parameter int PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + PS_W'(1);
  end

  assign tick = run && !clr && (div_q == LAST);
endmodule

// File: rtl/esc_wdg_counter.sv
module esc_wdg_counter #(
  parameter int LEN_W    = 16,
  parameter int LOW_BITS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [LEN_W-1:0]          load_len,
  input  logic                      tick,
  output logic [LEN_W+LOW_BITS-1:0] cnt_q,
  output logic                      zero
);
  localparam int CNT_W = LEN_W + LOW_BITS;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= {load_len, {LOW_BITS{1'b0}}};
    else if (tick && cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/esc_wdg_escalate.sv
module esc_wdg_escalate
  import esc_wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop,
  input  logic       restart,
  input  logic       expire,
  input  logic [1:0] mode,
  input  logic       mgmt_en,
  output logic       core_set,
  output logic       reload_ok,
  output logic       mgmt_pulse,
  output logic       rst_pulse,
  output logic       done_q
);
  logic [1:0] stage_q, stage_d;
  logic       mgmt_fire, rst_fire, finish;

  always_comb begin
    stage_d   = stage_q;
    core_set  = 1'b0;
    mgmt_fire = 1'b0;
    rst_fire  = 1'b0;
    finish    = 1'b0;
    if (expire) begin
      case (wdg_mode_e'(mode))
        MODE_CORE: begin
          core_set = 1'b1;
          stage_d  = 2'd0;
        end
        MODE_MGMT: begin
          if (stage_q == 2'd0) begin
            core_set = 1'b1;
            stage_d  = 2'd1;
          end else begin
            mgmt_fire = mgmt_en;
            finish    = 1'b1;
            stage_d   = 2'd2;
          end
        end
        MODE_FULL: begin
          if (stage_q == 2'd0) begin
            core_set = 1'b1;
            stage_d  = 2'd1;
          end else if (stage_q == 2'd1) begin
            mgmt_fire = mgmt_en;
            stage_d   = 2'd2;
          end else begin
            rst_fire = 1'b1;
            finish   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign reload_ok = expire && !finish;

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      stage_q    <= 2'd0;
      done_q     <= 1'b0;
      mgmt_pulse <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      stage_q    <= restart ? 2'd0 : stage_d;
      done_q     <= done_q || finish;
      mgmt_pulse <= mgmt_fire;
      rst_pulse  <= rst_fire;
    end
  end
endmodule

// File: rtl/esc_wdg_regs.sv
module esc_wdg_regs
  import esc_wdg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int LOW_BITS = 8,
  parameter int IDX      = 63
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic                      reg_rd,
  input  logic [2:0]                reg_addr,
  input  logic [63:0]               reg_wdata,
  input  logic                      core_set,
  input  logic [LEN_W+LOW_BITS-1:0] cnt,
  output logic [1:0]                mode_q,
  output logic                      mgmt_en_q,
  output logic [LEN_W-1:0]          len_q,
  output logic                      pend_q,
  output logic                      en_q,
  output logic                      stop,
  output logic                      start,
  output logic                      poke_hit,
  output logic [63:0]               rdata_q
);
  localparam int CNT_W   = LEN_W + LOW_BITS;
  localparam int CNT_LSB = LEN_LSB + LEN_W;

  logic        ctl_wr, pend_clr, en_set, en_clr;
  logic [63:0] rd_mux;

  assign ctl_wr   = reg_we && (reg_addr == ADR_CTRL);
  assign stop     = ctl_wr && (reg_wdata[1:0] == 2'd0);
  assign start    = ctl_wr && (reg_wdata[1:0] != 2'd0) && (mode_q == 2'd0);
  assign poke_hit = reg_we && (reg_addr == ADR_POKE)  && reg_wdata[IDX];
  assign pend_clr = reg_we && (reg_addr == ADR_PEND)  && reg_wdata[IDX];
  assign en_set   = reg_we && (reg_addr == ADR_ENSET) && reg_wdata[IDX];
  assign en_clr   = reg_we && (reg_addr == ADR_ENCLR) && reg_wdata[IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 2'd0;
      mgmt_en_q <= 1'b0;
      len_q     <= '0;
    end else if (ctl_wr) begin
      mode_q    <= reg_wdata[1:0];
      mgmt_en_q <= reg_wdata[MGMT_EN_BIT];
      len_q     <= reg_wdata[LEN_LSB +: LEN_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= core_set || (pend_q && !pend_clr);
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_CTRL: begin
        rd_mux[1:0]                = mode_q;
        rd_mux[MGMT_EN_BIT]        = mgmt_en_q;
        rd_mux[LEN_LSB +: LEN_W]   = len_q;
        rd_mux[CNT_LSB +: CNT_W]   = cnt;
      end
      ADR_PEND:             rd_mux[IDX] = pend_q;
      ADR_ENSET, ADR_ENCLR: rd_mux[IDX] = en_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog #(
  parameter int PRESCALE = 1024,
  parameter int LEN_W    = 16,
  parameter int LOW_BITS = 8,
  parameter int IDX      = 63
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        irq_core,
  output logic        irq_mgmt,
  output logic        rst_req
);
  localparam int CNT_W = LEN_W + LOW_BITS;

  logic [1:0]       mode_q;
  logic             mgmt_en_q, pend_q, en_q;
  logic [LEN_W-1:0] len_q, load_len;
  logic [CNT_W-1:0] cnt_q;
  logic             stop, start, poke_hit, poke_ok, restart;
  logic             run, tick, cnt_zero, expire, load;
  logic             core_set, reload_ok, done_q;

  esc_wdg_regs #(.LEN_W(LEN_W), .LOW_BITS(LOW_BITS), .IDX(IDX)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .core_set(core_set),
    .cnt(cnt_q), .mode_q(mode_q), .mgmt_en_q(mgmt_en_q), .len_q(len_q),
    .pend_q(pend_q), .en_q(en_q), .stop(stop), .start(start),
    .poke_hit(poke_hit), .rdata_q(reg_rdata)
  );

  assign run     = (mode_q != 2'd0) && !done_q;
  assign poke_ok = poke_hit && !done_q;
  assign restart = start || poke_ok;

  esc_wdg_prescaler #(.PRESCALE(PRESCALE)) presc_i (
    .clk(clk), .rst(rst), .clr(stop || restart), .run(run), .tick(tick)
  );

  assign expire   = tick && cnt_zero;
  assign load     = restart || reload_ok;
  assign load_len = start ? reg_wdata[esc_wdg_pkg::LEN_LSB +: LEN_W] : len_q;

  esc_wdg_counter #(.LEN_W(LEN_W), .LOW_BITS(LOW_BITS)) cnt_i (
    .clk(clk), .rst(rst), .load(load), .load_len(load_len),
    .tick(tick), .cnt_q(cnt_q), .zero(cnt_zero)
  );

  esc_wdg_escalate esc_i (
    .clk(clk), .rst(rst), .stop(stop), .restart(restart), .expire(expire),
    .mode(mode_q), .mgmt_en(mgmt_en_q), .core_set(core_set),
    .reload_ok(reload_ok), .mgmt_pulse(irq_mgmt), .rst_pulse(rst_req),
    .done_q(done_q)
  );

  assign irq_core = pend_q && en_q;
endmodule

// File: rtl/esc_watchdog_chk.sv
module esc_watchdog_chk #(
  parameter int LOW_BITS = 8,
  parameter int IDX      = 63,
  parameter int CNT_W    = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [63:0]      reg_wdata,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             done_q,
  input logic             core_set,
  input logic             pend_q,
  input logic             irq_mgmt,
  input logic             rst_req
);
  // R7
  mgmt_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_mgmt |=> !irq_mgmt);

  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> done_q);

  // R4
  start_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'd0 && reg_wdata[1:0] != 2'd0 && mode_q == 2'd0)
    |=> (cnt_q[LOW_BITS-1:0] == '0));

  // R2
  off_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && !reg_we) |=> $stable(cnt_q));

  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'd1 && reg_wdata[IDX] && !core_set) |=> !pend_q);
endmodule

bind esc_watchdog esc_watchdog_chk #(.LOW_BITS(LOW_BITS), .IDX(IDX), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_q(mode_q), .cnt_q(cnt_q), .done_q(done_q),
  .core_set(core_set), .pend_q(pend_q), .irq_mgmt(irq_mgmt), .rst_req(rst_req)
);

// File: tb/esc_watchdog_tb_top.sv
module esc_watchdog_tb_top;
  localparam int PS   = 4;
  localparam int LOWB = 2;
  localparam int IDX  = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq_core, irq_mgmt, rst_req;

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  esc_watchdog #(.PRESCALE(PS), .LEN_W(16), .LOW_BITS(LOWB), .IDX(IDX)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_core(irq_core),
    .irq_mgmt(irq_mgmt), .rst_req(rst_req)
  );

  // Behavioural reference model, stepped at each rising edge
  int          m_mode, m_men, m_len, m_cnt, m_div, m_stage;
  bit          m_done, m_pend, m_en, m_mgmt, m_rst;
  logic [63:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_men = 0; m_len = 0; m_cnt = 0; m_div = 0; m_stage = 0;
      m_done = 0; m_pend = 0; m_en = 0; m_mgmt = 0; m_rst = 0; m_rdata = '0;
    end else begin
      bit ctl, stop, start, poke, core;
      if (reg_rd) begin
        m_rdata = '0;
        if (reg_addr == 0)
          m_rdata = 64'(m_mode) | (64'(m_men) << 2) | (64'(m_len) << 4) | (64'(m_cnt) << 20);
        else if (reg_addr == 1) m_rdata[IDX] = m_pend;
        else if (reg_addr == 2 || reg_addr == 3) m_rdata[IDX] = m_en;
      end
      ctl   = reg_we && reg_addr == 0;
      stop  = ctl && reg_wdata[1:0] == 0;
      start = ctl && reg_wdata[1:0] != 0 && m_mode == 0;
      poke  = reg_we && reg_addr == 4 && reg_wdata[IDX] && !m_done;
      core  = 0; m_mgmt = 0; m_rst = 0;
      if (stop) begin
        m_div = 0; m_stage = 0; m_done = 0;
      end else if (start || poke) begin
        m_cnt = (start ? int'(reg_wdata[19:4]) : m_len) * (1 << LOWB);
        m_div = 0; m_stage = 0;
      end else if (m_mode != 0 && !m_done) begin
        if (m_div == PS - 1) begin
          m_div = 0;
          if (m_cnt != 0) m_cnt--;
          else begin
            // expiry number m_stage+1
            if (m_mode == 1) begin core = 1; m_stage = 0; end
            else if (m_stage == 0) begin core = 1; m_stage = 1; end
            else if (m_mode == 2) begin m_mgmt = m_men[0]; m_stage = 2; m_done = 1; end
            else if (m_stage == 1) begin m_mgmt = m_men[0]; m_stage = 2; end
            else begin m_rst = 1; m_done = 1; end
            if (!m_done) m_cnt = m_len * (1 << LOWB);
          end
        end else m_div++;
      end
      if (ctl) begin
        m_mode = int'(reg_wdata[1:0]); m_men = int'(reg_wdata[2]); m_len = int'(reg_wdata[19:4]);
      end
      if (reg_we && reg_addr == 1 && reg_wdata[IDX]) m_pend = 0;
      if (core) m_pend = 1;
      if (reg_we && reg_addr == 2 && reg_wdata[IDX]) m_en = 1;
      if (reg_we && reg_addr == 3 && reg_wdata[IDX]) m_en = 0;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq_core !== (m_pend & m_en) || irq_mgmt !== m_mgmt || rst_req !== m_rst ||
          reg_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s: core/mgmt/rst/rdata = %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                 tag, irq_core, irq_mgmt, rst_req, reg_rdata,
                 m_pend & m_en, m_mgmt, m_rst, m_rdata);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  function automatic logic [63:0] ctl_word(int mode, int men, int len);
    return 64'(mode) | (64'(men) << 2) | (64'(len) << 4);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [63:0] BIT_IDX = 64'd1 << IDX;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tag = "R1"; rd(0); rd(1); rd(2);
    tag = "R3"; wr(0, ctl_word(0, 1, 5)); rd(0);
    tag = "R4"; wr(0, ctl_word(1, 1, 3)); rd(0); idle(5); rd(0);
    tag = "R12"; wr(2, BIT_IDX); rd(3);
    tag = "R5"; for (int k = 0; k < 12; k++) begin idle(3); rd(0); end
    tag = "R6"; idle(90); rd(1);
    tag = "R11"; wr(1, 64'd1); rd(1); wr(1, BIT_IDX); rd(1);
    tag = "R12"; idle(60); wr(3, BIT_IDX); idle(4); wr(2, BIT_IDX); idle(4);
    tag = "R13"; wr(0, ctl_word(0, 1, 3)); rd(0);
    tag = "R2"; idle(50); rd(0);
    tag = "R13"; wr(0, ctl_word(3, 1, 2)); rd(0);
    tag = "R10"; idle(20); wr(4, BIT_IDX); rd(0); idle(20);
    wr(4, 64'd1 << 62); rd(0);
    tag = "R8"; idle(150); wr(4, BIT_IDX); rd(0); idle(30);
    tag = "R7"; wr(0, ctl_word(0, 1, 2)); wr(0, ctl_word(2, 1, 2)); idle(120); rd(0);
    tag = "R9"; wr(0, ctl_word(0, 0, 2)); wr(1, BIT_IDX); wr(0, ctl_word(3, 0, 2));
    idle(150); rd(0);
    tag = "R6"; wr(0, ctl_word(0, 1, 1)); wr(0, ctl_word(3, 1, 1)); idle(25);
    wr(0, ctl_word(1, 1, 1)); idle(80); rd(1);
    idle(5);
    finish_run();
  end
endmodule